// File: doc/BRIEF.md
# Receive Interrupt Coalescing Unit

This block decides when a packet receive queue should interrupt its host. Instead of raising an interrupt for every arriving frame, it waits until one of three enabled conditions is past its programmed limit. The conditions are the number of frames waiting in the queue, the number of data bytes they hold, and the time in microseconds since a frame landed in an empty queue.

The queue reports each frame it adds or removes, together with that frame's byte length. A free-running microsecond tick drives the timer. Software programs the limits and enables through a small write port. When an enabled condition starts to hold, a sticky status bit sets, and so does a flag that names the cause. Software clears the status bit and all flags by writing a one. The interrupt pin is the status bit gated by an interrupt enable.

Top module: `rxIrqCoalesce`

## Requirements
- R1: `frameCount` and `byteCount` track frames and bytes in the queue one cycle after each event. An add and a remove in the same cycle change each count by their net difference.
- R2: With the frame enable (control bit 0) set, `frameCount` greater than the frame limit (address 1) sets `irqStatus` and `causeFlags[0]`.
- R3: With the byte enable (control bit 1) set, `byteCount` greater than the byte limit (address 2) sets `irqStatus` and `causeFlags[1]`.
- R4: The elapsed timer restarts at zero when a frame enters an empty queue. It then counts `usTick` pulses and returns to zero when the queue empties. With the time enable (control bit 2) set, an elapsed count greater than the duration limit (address 3) sets `irqStatus` and `causeFlags[2]`.
- R5: A duration limit written above 0xCFFF is stored as 0xCFFF.
- R6: Status and flags are set by a condition that becomes true, not by a level. A condition that stays true after a clear does not set them again until it has gone false and become true once more.
- R7: Writing address 4 with data bit 0 set clears `irqStatus` and all `causeFlags`. A condition that becomes true in the same cycle still sets them.
- R8: `irqOut` is high exactly when `irqStatus` is high and the interrupt enable (control bit 3) is set.
- R9: After reset, all outputs, counts, limits and enables are zero.
- R10: Each status update happens on the clock edge after the counts change. Writes take effect on the clock edge where `cfgWrEn` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | A frame entered the queue |
| enqBytes | input | LEN_W | Byte length of that frame |
| deqValid | input | 1 | A frame left the queue |
| deqBytes | input | LEN_W | Byte length of that frame |
| usTick | input | 1 | One-cycle pulse every microsecond |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address: 0 control, 1 frame limit, 2 byte limit, 3 duration limit, 4 clear |
| cfgWrData | input | 16 | Register write data |
| irqOut | output | 1 | Receive interrupt |
| irqStatus | output | 1 | Sticky interrupt status |
| causeFlags | output | 3 | Per-condition flags: bit 0 frames, bit 1 bytes, bit 2 time |
| frameCount | output | FRAME_W | Frames in the queue |
| byteCount | output | BYTE_W | Bytes in the queue |

## Verification
A wrong count shows on `frameCount` or `byteCount` on the very next clock edge. A condition compared against the wrong value shows on the edge after that, as a missing or extra status bit or flag. A fault in the edge detector shows only after a clear: a level-sensitive design sets the status again one cycle after the clear while the condition still holds. A timer fault, such as a missed restart or an unsaturated limit, appears the cycle after the elapsed count passes the limit. At the largest limit that is more than 53,000 ticks after the frame arrives.

// File: rtl/rxIrqPkg.sv
package rxIrqPkg;
  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_FRAME = 3'd1;
  localparam logic [2:0] ADDR_BYTE  = 3'd2;
  localparam logic [2:0] ADDR_TIME  = 3'd3;
  localparam logic [2:0] ADDR_CLEAR = 3'd4;

  // condition strobes from datapath to control, unmasked
  typedef struct packed {
    logic timeHit;
    logic byteHit;
    logic frameHit;
  } hitT;
endpackage

// File: rtl/rxIrqDatapath.sv
module rxIrqDatapath
  import rxIrqPkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int BYTE_W  = 16,
  parameter int LEN_W   = 11,
  parameter int TIME_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enqValid,
  input  logic [LEN_W-1:0]   enqBytes,
  input  logic               deqValid,
  input  logic [LEN_W-1:0]   deqBytes,
  input  logic               usTick,
  input  logic [FRAME_W-1:0] frameThr,
  input  logic [BYTE_W-1:0]  byteThr,
  input  logic [TIME_W-1:0]  durThr,
  output hitT                hits,
  output logic [FRAME_W-1:0] frameCount,
  output logic [BYTE_W-1:0]  byteCount
);
  localparam logic [TIME_W-1:0] ELAPSED_MAX = {TIME_W{1'b1}};

  logic [FRAME_W-1:0] frameNext;
  logic [BYTE_W-1:0]  byteNext;
  logic [TIME_W-1:0]  elapsed;

  always_comb begin
    frameNext = frameCount + FRAME_W'(enqValid) - FRAME_W'(deqValid);
    byteNext  = byteCount
              + (enqValid ? BYTE_W'(enqBytes) : '0)
              - (deqValid ? BYTE_W'(deqBytes) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCount <= '0;
      byteCount  <= '0;
      elapsed    <= '0;
    end else begin
      frameCount <= frameNext;
      byteCount  <= byteNext;
      if (frameNext == '0)
        elapsed <= '0;                       // queue drained: stop
      else if (frameCount == '0)
        elapsed <= '0;                       // first frame: rearm
      else if (usTick && elapsed != ELAPSED_MAX)
        elapsed <= elapsed + 1'b1;
    end
  end

  always_comb begin
    hits.frameHit = frameCount > frameThr;
    hits.byteHit  = byteCount > byteThr;
    hits.timeHit  = elapsed > durThr;
  end

  assert_timer_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameCount == '0) |-> (elapsed == '0));

  assert_net_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid && deqValid && enqBytes == deqBytes) |=> ($stable(frameCount) && $stable(byteCount)));
endmodule

// File: rtl/rxIrqCtrl.sv
module rxIrqCtrl
  import rxIrqPkg::*;
#(
  parameter int               FRAME_W  = 8,
  parameter int               BYTE_W   = 16,
  parameter int               TIME_W   = 16,
  parameter logic [TIME_W-1:0] TIME_MAX = 16'hCFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [2:0]         cfgAddr,
  input  logic [15:0]        cfgWrData,
  input  hitT                hits,
  output logic [FRAME_W-1:0] frameThr,
  output logic [BYTE_W-1:0]  byteThr,
  output logic [TIME_W-1:0]  durThr,
  output logic               irqOut,
  output logic               irqStatus,
  output logic [2:0]         causeFlags
);
  logic [3:0] ctrlReg;   // [0] frame en, [1] byte en, [2] time en, [3] irq en
  logic [2:0] condNow, condPrev, rise;
  logic       clrNow;
  logic [TIME_W-1:0] durWrite;

  always_comb begin
    condNow  = {hits.timeHit, hits.byteHit, hits.frameHit} & ctrlReg[2:0];
    rise     = condNow & ~condPrev;
    clrNow   = cfgWrEn && (cfgAddr == ADDR_CLEAR) && cfgWrData[0];
    durWrite = (TIME_W'(cfgWrData) > TIME_MAX) ? TIME_MAX : TIME_W'(cfgWrData);
    irqOut   = irqStatus & ctrlReg[3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      frameThr   <= '0;
      byteThr    <= '0;
      durThr     <= '0;
      condPrev   <= '0;
      causeFlags <= '0;
      irqStatus  <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        unique case (cfgAddr)
          ADDR_CTRL:  ctrlReg  <= cfgWrData[3:0];
          ADDR_FRAME: frameThr <= FRAME_W'(cfgWrData);
          ADDR_BYTE:  byteThr  <= BYTE_W'(cfgWrData);
          ADDR_TIME:  durThr   <= durWrite;
          default: ;
        endcase
      end
      condPrev   <= condNow;
      causeFlags <= (clrNow ? 3'b000 : causeFlags) | rise;
      irqStatus  <= (clrNow ? 1'b0 : irqStatus) | (|rise);
    end
  end

  assert_dur_sat_R5: assert property (@(posedge clk) disable iff (!rstN)
    durThr <= TIME_MAX);

  assert_flag_implies_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    (causeFlags != 3'b000) |-> irqStatus);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrNow && rise == 3'b000) |=> (!irqStatus && causeFlags == 3'b000));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus && !clrNow) |=> irqStatus);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqStatus);
endmodule

// File: rtl/rxIrqCoalesce.sv
module rxIrqCoalesce
  import rxIrqPkg::*;
#(
  parameter int               FRAME_W  = 8,
  parameter int               BYTE_W   = 16,
  parameter int               LEN_W    = 11,
  parameter int               TIME_W   = 16,
  parameter logic [TIME_W-1:0] TIME_MAX = 16'hCFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enqValid,
  input  logic [LEN_W-1:0]   enqBytes,
  input  logic               deqValid,
  input  logic [LEN_W-1:0]   deqBytes,
  input  logic               usTick,
  input  logic               cfgWrEn,
  input  logic [2:0]         cfgAddr,
  input  logic [15:0]        cfgWrData,
  output logic               irqOut,
  output logic               irqStatus,
  output logic [2:0]         causeFlags,
  output logic [FRAME_W-1:0] frameCount,
  output logic [BYTE_W-1:0]  byteCount
);
  hitT                hits;
  logic [FRAME_W-1:0] frameThr;
  logic [BYTE_W-1:0]  byteThr;
  logic [TIME_W-1:0]  durThr;

  rxIrqDatapath #(
    .FRAME_W(FRAME_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .TIME_W(TIME_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqBytes(enqBytes),
    .deqValid(deqValid), .deqBytes(deqBytes),
    .usTick(usTick),
    .frameThr(frameThr), .byteThr(byteThr), .durThr(durThr),
    .hits(hits), .frameCount(frameCount), .byteCount(byteCount)
  );

  rxIrqCtrl #(
    .FRAME_W(FRAME_W), .BYTE_W(BYTE_W), .TIME_W(TIME_W), .TIME_MAX(TIME_MAX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .hits(hits),
    .frameThr(frameThr), .byteThr(byteThr), .durThr(durThr),
    .irqOut(irqOut), .irqStatus(irqStatus), .causeFlags(causeFlags)
  );
endmodule

// File: tb/test_rxIrqCoalesce.sv
`timescale 1ns/1ps
module test_rxIrqCoalesce;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enqValid = 1'b0, deqValid = 1'b0, usTick = 1'b0, cfgWrEn = 1'b0;
  logic [10:0] enqBytes = '0, deqBytes = '0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        irqOut, irqStatus;
  logic [2:0]  causeFlags;
  logic [7:0]  frameCount;
  logic [15:0] byteCount;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  rxIrqCoalesce i_rxIrqCoalesce (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqBytes(enqBytes),
    .deqValid(deqValid), .deqBytes(deqBytes), .usTick(usTick),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .irqOut(irqOut), .irqStatus(irqStatus), .causeFlags(causeFlags),
    .frameCount(frameCount), .byteCount(byteCount)
  );

  // reference model, built from the requirements
  logic [3:0]  mCtrl;
  logic [7:0]  mFthr, mFrames;
  logic [15:0] mBthr, mDthr, mBytes, mTimer;
  logic [2:0]  mPrev, mFlags;
  logic        mStatus;
  logic [10:0] lenQ [256];
  logic [7:0]  qHead, qTail;

  function automatic logic [15:0] satDur(input logic [15:0] d); // R5
    return (d > 16'hCFFF) ? 16'hCFFF : d;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mFthr = 0; mBthr = 0; mDthr = 0; mFrames = 0; mBytes = 0;
      mTimer = 0; mPrev = 0; mFlags = 0; mStatus = 0; qHead = 0; qTail = 0;
    end else begin
      logic [2:0] c, rise;
      logic clr;
      logic [7:0] nf;
      c[0] = mFrames > mFthr; c[1] = mBytes > mBthr; c[2] = mTimer > mDthr;
      c = c & mCtrl[2:0];
      rise = c & ~mPrev; mPrev = c;
      clr = cfgWrEn && cfgAddr == 3'd4 && cfgWrData[0];
      mFlags  = (clr ? 3'b0 : mFlags) | rise;
      mStatus = (clr ? 1'b0 : mStatus) | (|rise);
      if (cfgWrEn) begin  // R10 register map
        case (cfgAddr)
          3'd0: mCtrl = cfgWrData[3:0];
          3'd1: mFthr = cfgWrData[7:0];
          3'd2: mBthr = cfgWrData;
          3'd3: mDthr = satDur(cfgWrData);
          default: ;
        endcase
      end
      nf = mFrames + 8'(enqValid) - 8'(deqValid);
      if (nf == 0) mTimer = 0;
      else if (mFrames == 0) mTimer = 0;
      else if (usTick && mTimer != 16'hFFFF) mTimer = mTimer + 1;
      mBytes = mBytes + (enqValid ? 16'(enqBytes) : 16'd0) - (deqValid ? 16'(deqBytes) : 16'd0);
      mFrames = nf;
      if (enqValid) begin lenQ[qTail] = enqBytes; qTail = qTail + 1; end
      if (deqValid) qHead = qHead + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1 frameCount", 32'(frameCount), 32'(mFrames));
    chk("R1 byteCount", 32'(byteCount), 32'(mBytes));
    chk("R2/R3/R4 causeFlags", 32'(causeFlags), 32'(mFlags));
    chk("R6/R7 irqStatus", 32'(irqStatus), 32'(mStatus));
    chk("R8 irqOut", 32'(irqOut), 32'(mStatus & mCtrl[3]));
  endtask

  // one cycle: check the result of the previous cycle, then drive new inputs
  task automatic step(input bit enq, input logic [10:0] el, input bit deq,
                      input bit tick, input bit we, input logic [2:0] a,
                      input logic [15:0] d);
    @(negedge clk);
    compareAll();
    enqValid = enq; enqBytes = el;
    deqValid = deq && (mFrames != 0);
    deqBytes = lenQ[qHead];
    usTick = tick; cfgWrEn = we; cfgAddr = a; cfgWrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; enqValid = 0; deqValid = 0; usTick = 0; cfgWrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin : watchdog
    #1_700_000;
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    // R9: reset state
    @(negedge clk);
    chk("R9 irqOut", 32'(irqOut), 0);
    chk("R9 irqStatus", 32'(irqStatus), 0);
    chk("R9 causeFlags", 32'(causeFlags), 0);
    chk("R9 frameCount", 32'(frameCount), 0);
    chk("R9 byteCount", 32'(byteCount), 0);

    // R2, R6: frame limit 1, enqueue two frames, then clear while still over
    step(0, 0, 0, 0, 1, 3'd0, 16'h0009);
    step(0, 0, 0, 0, 1, 3'd1, 16'd1);
    step(0, 0, 0, 0, 1, 3'd2, 16'hFFFF);
    step(1, 11'd100, 0, 0, 0, 0, 0);
    step(1, 11'd200, 0, 0, 0, 0, 0);
    idle(2);
    @(negedge clk);
    chk("R2 frame flag", 32'(causeFlags), 32'd1);
    chk("R8 irq asserted", 32'(irqOut), 32'd1);
    step(0, 0, 0, 0, 1, 3'd4, 16'h0001);
    idle(3);
    @(negedge clk);
    chk("R6 no re-set while level held", 32'(irqStatus), 32'd0);
    // R1: simultaneous add and remove
    step(1, 11'd300, 1, 0, 0, 0, 0);
    idle(1);
    @(negedge clk);
    chk("R1 net frame count", 32'(frameCount), 32'd2);
    chk("R1 net byte count", 32'(byteCount), 32'd500);
    // R6: fall then rise sets again
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 11'd64, 0, 0, 0, 0, 0);
    idle(2);
    @(negedge clk);
    chk("R6 re-set after fall and rise", 32'(irqStatus), 32'd1);
    // R7: clear coinciding with a new rise keeps the status set
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 11'd64, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3'd4, 16'h0001);
    idle(1);
    @(negedge clk);
    chk("R7 set wins over clear", 32'(irqStatus), 32'd1);

    // R5: duration limit saturation, long run of ticks
    doReset();
    step(0, 0, 0, 0, 1, 3'd0, 16'h000C);
    step(0, 0, 0, 0, 1, 3'd3, 16'hFFFF);
    step(1, 11'd80, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16'hCFFF + 4; i++) step(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R5 saturated limit fired", 32'(irqOut), 32'd1);
    chk("R4 time flag", 32'(causeFlags), 32'd4);

    // constrained random mix
    doReset();
    for (int i = 0; i < 4000; i++) begin
      bit we, enq;
      logic [2:0] a;
      logic [15:0] d;
      we = ($urandom % 12) == 0;
      a = 3'($urandom % 5);
      case (a)
        3'd0: d = 16'($urandom % 16);
        3'd1: d = 16'($urandom % 6);
        3'd2: d = 16'($urandom % 5000);
        3'd3: d = ($urandom % 8 == 0) ? 16'hE000 : 16'($urandom % 40);
        default: d = 16'($urandom % 2);
      endcase
      enq = ($urandom % 10 < 4) && mFrames < 200 && mBytes < 60000;
      step(enq, 11'(64 + $urandom % 1455), ($urandom % 10) < 4,
           ($urandom % 3) == 0, we, a, d);
    end
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule